// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a memory-mapped watchdog for a processor subsystem. A down-counter is loaded with a timeout length that is fixed when the design is built. Software arms it once by setting a start bit in the control word. After that the counter runs until the next system reset, and no register write can halt it.

Software keeps the system alive by writing to either half of the period register. The data written is thrown away. The write only reloads the counter to its full length. If the counter runs out with no such write, the block raises a reset-request pulse toward the processor. It also latches a timeout flag that software can read and clear.

The default timeout is 124,999,999 plus one cycles. At a 125 MHz clock that is one second. The register window is eight 32-bit words, addressed by word index. Reads are combinational and have no side effects.

Top module: `lock_watchdog`

## Requirements
- R1: After synchronous reset the watchdog is stopped, `resetRequest` is low, the status word (index 0) reads 0 and the control word (index 1) reads 0.
- R2: A write to word index 1 with bit 2 set (0x4) starts the watchdog. With no feed, `resetRequest` rises RELOAD+1 cycles after the clock edge that took the start write.
- R3: Once running, the watchdog cannot be halted. A control write with bit 3 set (0x8) or with bit 2 clear leaves status bit 1 at 1, and the next expiry still happens on schedule.
- R4: While running, a write of any data to word index 2 or 3 reloads the counter. The next expiry then comes RELOAD+1 cycles after that write's edge.
- R5: A feed write taken on the same edge at which the counter would expire wins. No reset request is raised, and the counter restarts from the full length.
- R6: Each expiry drives `resetRequest` high for exactly PULSE_LEN cycles. The counter reloads at expiry and keeps running, so a further unfed period expires again RELOAD+1 cycles later.
- R7: Status word (index 0): bit 0 is the timeout flag, set by an expiry; bit 1 is the running state. Any write to index 0 clears bit 0 and leaves bit 1 unchanged.
- R8: Word index 2 reads RELOAD[15:0] and index 3 reads RELOAD[31:16], zero-extended. Writes to them do not change what they read back.
- R9: Control bits 0 and 1 are stored and read back from index 1. Bit 2 reads the running state and bit 3 always reads 0. Bits 0 and 1 have no effect on timing.
- R10: Feed writes before start have no effect, so no reset request ever appears. Word indices 4 to 7 read zero, and writes to them are ignored.
- R11: A synchronous reset applied while running returns the block to the stopped state. No reset request follows unless the block is started again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| address | input | ADDR_W | Word index into the register window |
| write | input | 1 | Write strobe |
| writedata | input | DATA_W | Write data |
| read | input | 1 | Read strobe; `readdata` is zero when low |
| readdata | output | DATA_W | Combinational read data |
| resetRequest | output | 1 | Registered reset-request pulse toward the processor |

## Verification
The bench targets four corner cases.
- A feed that lands exactly on the expiry edge. A design that gives expiry priority would fire a reset request despite a timely feed.
- Stop-like control writes after start. A design that honours them would never fire again, and the bench's expected rising edge would go missing.
- Pulse width and automatic re-arming. A miscounted width or a counter left stuck at zero shows up as a wrong pulse length or a second rise at the wrong cycle.
- Feeds before start and writes to unused words. A design that lets either start or disturb the counter produces an unexpected rise, which the scoreboard reports.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // Strobes from the register control to the counting datapath.
  typedef struct packed {
    logic start;   // arm request, only raised while stopped
    logic feed;    // reload request from a period-word write
  } wdgStrobe_t;

  // Word indices; software depends on these.
  localparam int IDX_STATUS  = 0;
  localparam int IDX_CTRL    = 1;
  localparam int IDX_PER_LO  = 2;
  localparam int IDX_PER_HI  = 3;

  // Control word bit positions.
  localparam int BIT_START = 2;
  localparam int BIT_STOP  = 3;

endpackage

// File: rtl/wdg_count.sv
module wdg_count
  import wdg_pkg::*;
#(
  parameter int RELOAD    = 124_999_999,
  parameter int PULSE_LEN = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  wdgStrobe_t strobe,
  output logic       running,
  output logic       expire,
  output logic       resetRequest
);

  localparam int CNT_W   = $clog2(RELOAD + 1);
  localparam int PULSE_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0]   CNT_FULL  = CNT_W'(RELOAD);
  localparam logic [PULSE_W-1:0] PULSE_SET = PULSE_W'(PULSE_LEN);

  logic [CNT_W-1:0]   cnt;
  logic [PULSE_W-1:0] pulseCnt;
  logic               cntZero;

  assign cntZero = (cnt == '0);
  // A feed on the zero cycle wins over expiry.
  assign expire  = running && cntZero && !strobe.feed;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= CNT_FULL;
    end else begin
      if (strobe.start) begin
        running <= 1'b1;
      end
      if (!running || strobe.feed || cntZero) begin
        cnt <= CNT_FULL;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulseCnt     <= '0;
      resetRequest <= 1'b0;
    end else begin
      if (expire) begin
        pulseCnt <= PULSE_SET;
      end else if (pulseCnt != '0) begin
        pulseCnt <= pulseCnt - PULSE_W'(1);
      end
      resetRequest <= expire || (pulseCnt > PULSE_W'(1));
    end
  end

  // R3: running never clears without reset
  a_r3_locked_running: assert property (@(posedge clk) disable iff (rst)
    running |=> running);

  // R1: a stopped counter holds the full length
  a_r1_idle_full: assert property (@(posedge clk) disable iff (rst)
    !running |-> (cnt == CNT_FULL));

  // R4: a feed from the control side reloads the counter
  a_r4_feed_reload: assert property (@(posedge clk) disable iff (rst)
    (strobe.feed && running) |=> (cnt == CNT_FULL));

  // R6: expiry raises the request on the next cycle
  a_r6_expire_pulse: assert property (@(posedge clk) disable iff (rst)
    expire |=> resetRequest);

  // R10: no request while the watchdog was never started
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !running |=> !resetRequest);

endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int RELOAD = 124_999_999
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] address,
  input  logic              write,
  input  logic [DATA_W-1:0] writedata,
  input  logic              read,
  input  logic              running,
  input  logic              expire,
  output wdgStrobe_t        strobe,
  output logic [DATA_W-1:0] readdata
);

  localparam logic [31:0] RELOAD_VEC = 32'(RELOAD);

  logic [1:0]        ctrlKeep;
  logic              timeoutFlag;
  logic              selStatus, selCtrl, selPerLo, selPerHi;
  logic [DATA_W-1:0] muxData;
  logic              unusedData;

  assign selStatus = (address == ADDR_W'(IDX_STATUS));
  assign selCtrl   = (address == ADDR_W'(IDX_CTRL));
  assign selPerLo  = (address == ADDR_W'(IDX_PER_LO));
  assign selPerHi  = (address == ADDR_W'(IDX_PER_HI));

  // Only bits 0..2 of write data matter; the rest is discarded.
  assign unusedData = ^writedata[DATA_W-1:3];

  assign strobe.start = write && selCtrl && writedata[BIT_START] && !running;
  assign strobe.feed  = write && (selPerLo || selPerHi);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlKeep    <= 2'b00;
      timeoutFlag <= 1'b0;
    end else begin
      if (write && selCtrl) begin
        ctrlKeep <= writedata[1:0];
      end
      if (expire) begin
        timeoutFlag <= 1'b1;
      end else if (write && selStatus) begin
        timeoutFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    muxData = '0;
    if (selStatus) begin
      muxData[1:0] = {running, timeoutFlag};
    end else if (selCtrl) begin
      muxData[BIT_STOP]  = 1'b0;
      muxData[BIT_START] = running;
      muxData[1:0]       = ctrlKeep;
    end else if (selPerLo) begin
      muxData[15:0] = RELOAD_VEC[15:0];
    end else if (selPerHi) begin
      muxData[15:0] = RELOAD_VEC[31:16];
    end
  end

  assign readdata = read ? muxData : '0;

  // R7: expiry from the datapath sets the flag
  a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
    expire |=> timeoutFlag);

  // R7: a status write without a coincident expiry clears the flag
  a_r7_flag_clear: assert property (@(posedge clk) disable iff (rst)
    (write && selStatus && !expire) |=> !timeoutFlag);

  // R2: start strobe only while stopped
  a_r2_start_once: assert property (@(posedge clk) disable iff (rst)
    strobe.start |-> !running);

endmodule

// File: rtl/lock_watchdog.sv
module lock_watchdog
  import wdg_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32,
  parameter int RELOAD    = 124_999_999,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] address,
  input  logic              write,
  input  logic [DATA_W-1:0] writedata,
  input  logic              read,
  output logic [DATA_W-1:0] readdata,
  output logic              resetRequest
);

  wdgStrobe_t strobe;
  logic       running;
  logic       expire;

  wdg_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .RELOAD (RELOAD)
  ) i_regs (
    .clk       (clk),
    .rst       (rst),
    .address   (address),
    .write     (write),
    .writedata (writedata),
    .read      (read),
    .running   (running),
    .expire    (expire),
    .strobe    (strobe),
    .readdata  (readdata)
  );

  wdg_count #(
    .RELOAD    (RELOAD),
    .PULSE_LEN (PULSE_LEN)
  ) i_count (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .running      (running),
    .expire       (expire),
    .resetRequest (resetRequest)
  );

endmodule

// File: tb/test_lock_watchdog.sv
module test_lock_watchdog;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int RELOAD = 40;
  localparam int PULSE  = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] address = '0;
  logic              write = 1'b0;
  logic [DATA_W-1:0] writedata = '0;
  logic              read = 1'b0;
  logic [DATA_W-1:0] readdata;
  logic              resetRequest;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    int    at;
    string tag;
  } riseItem_t;

  riseItem_t expQ[$];

  lock_watchdog #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .RELOAD    (RELOAD),
    .PULSE_LEN (PULSE)
  ) i_lock_watchdog (
    .clk          (clk),
    .rst          (rst),
    .address      (address),
    .write        (write),
    .writedata    (writedata),
    .read         (read),
    .readdata     (readdata),
    .resetRequest (resetRequest)
  );

  always #4 clk = ~clk;  // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  // Driver side: queue an expected rising edge of the reset request.
  task automatic expectRise(input int at, input string tag);
    riseItem_t it;
    it.at  = at;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // Called at a negedge; returns at the negedge after the write edge.
  task automatic wr(input int a, input logic [31:0] d);
    address   = ADDR_W'(a);
    writedata = d;
    write     = 1'b1;
    @(negedge clk);
    write = 1'b0;
  endtask

  task automatic rdChk(input int a, input logic [31:0] expv, input string tag);
    logic [31:0] got;
    address = ADDR_W'(a);
    read    = 1'b1;
    #2;
    got = readdata;
    checks++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s: word %0d read 0x%08h expected 0x%08h", tag, a, got, expv);
    end
    @(negedge clk);
    read = 1'b0;
  endtask

  task automatic bitChk(input logic got, input logic expv, input string tag);
    checks++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, got, expv);
    end
  endtask

  task automatic waitUntil(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Monitor: match every rising edge against the queue and measure the width.
  logic prevReq = 1'b0;
  int   width   = 0;
  always @(negedge clk) begin
    if (rst) begin
      prevReq = 1'b0;
      width   = 0;
    end else begin
      if (resetRequest && !prevReq) begin
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R10/R5: unexpected reset request at cycle %0d, expected none", cyc);
        end else begin
          riseItem_t it;
          it = expQ.pop_front();
          if (it.at != cyc) begin
            fails++;
            $display("FAIL %s: reset request rose at cycle %0d expected %0d", it.tag, cyc, it.at);
          end
        end
        width = 1;
      end else if (resetRequest) begin
        width++;
      end else if (prevReq) begin
        checks++;
        if (width != PULSE) begin
          fails++;
          $display("FAIL R6: pulse width %0d expected %0d", width, PULSE);
        end
      end
      prevReq = resetRequest;
    end
  end

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected end earlier", cyc);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int w;
    int wf;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    bitChk(resetRequest, 1'b0, "R1 request low");
    rdChk(0, 32'h0, "R1 status");
    rdChk(1, 32'h0, "R1 control");

    // R8: period words, writes do not alter them
    rdChk(2, 32'd40, "R8 period low");
    rdChk(3, 32'd0, "R8 period high");

    // R10: feeds before start, unused words
    wr(2, 32'hDEAD_BEEF);
    wr(3, 32'h1234);
    wr(5, 32'hFFFF_FFFF);
    rdChk(2, 32'd40, "R8 period low after write");
    for (int k = 4; k < 8; k++) rdChk(k, 32'h0, "R10 unused word");
    repeat (60) @(negedge clk);
    bitChk(resetRequest, 1'b0, "R10 no request before start");
    rdChk(0, 32'h0, "R10 still stopped");

    // R9: stored control bits without start
    wr(1, 32'h3);
    rdChk(1, 32'h3, "R9 stored bits");
    rdChk(0, 32'h0, "R9 bits do not start");

    // R2: start, then R4 feeds at intervals shorter than the period
    wr(1, 32'h7);
    w = cyc;
    rdChk(1, 32'h7, "R9 start bit reads running");
    rdChk(0, 32'h2, "R2 running");
    for (int k = 0; k < 5; k++) begin
      waitUntil(w + 25);
      wr((k % 2 == 0) ? 2 : 3, 32'h0BAD_0000 + k);
      w = cyc;
    end
    wf = w;
    expectRise(wf + RELOAD + 1, "R4 expiry after last feed");
    expectRise(wf + 2 * (RELOAD + 1), "R6 re-armed expiry");

    // R3: stop-like writes are ignored
    wr(1, 32'h8);
    wr(1, 32'h0);
    rdChk(1, 32'h4, "R3 control after stop writes");
    rdChk(0, 32'h2, "R3 still running");

    // R7: flag set by expiry, cleared by status write
    waitUntil(wf + RELOAD + 1 + PULSE + 4);
    rdChk(0, 32'h3, "R7 timeout flag set");
    wr(0, 32'h0);
    rdChk(0, 32'h2, "R7 flag cleared, running kept");
    waitUntil(wf + 2 * (RELOAD + 1) + PULSE + 4);
    bitChk(expQ.size() == 0, 1'b1, "R3/R6 expected expiries seen");

    // R5: feed on the exact expiry edge
    wr(2, 32'h0);
    w = cyc;
    waitUntil(w + RELOAD);
    wr(3, 32'h5);
    checks++;
    if (cyc != w + RELOAD + 1) begin
      fails++;
      $display("FAIL R5: feed edge %0d expected %0d", cyc, w + RELOAD + 1);
    end
    w = cyc;
    expectRise(w + RELOAD + 1, "R5 expiry after coincident feed");
    waitUntil(w + RELOAD + 1 + PULSE + 4);
    bitChk(expQ.size() == 0, 1'b1, "R5 expiry seen");

    // R11: reset while running
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    bitChk(resetRequest, 1'b0, "R11 request low");
    rdChk(0, 32'h0, "R11 stopped");
    rdChk(1, 32'h0, "R11 control cleared");
    repeat (RELOAD + 20) @(negedge clk);
    bitChk(resetRequest, 1'b0, "R11 no request after reset");
    bitChk(expQ.size() == 0, 1'b1, "R11 queue drained");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule